// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits between a SEC-DED encoder and a pair of ECC-protected RAM instances. Each stored word is 39 bits wide, 32 data bits and 7 check bits. On a write it can invert one or two chosen bits of the outgoing word, so that the correction and detection logic on the read side can be tested with known faults. The write data, the computed check bits, a write enable and a RAM index come in. The possibly corrupted word and a per-RAM write enable go out.

A small control register holds the injection mode, a 7-bit bit-position code and the index of the targeted RAM. There are four mode enables: single-bit or two-bit, each in a continuous or a one-shot form. A one-shot mode corrupts only the next write to the targeted RAM and then clears itself. A two-bit injection also flips the parity check bit, so the decoder sees an uncorrectable pattern. A control value with more than one enable set is rejected: it injects nothing and raises a sticky flag.

Top module: `ecc_err_inject`

## Requirements
- R1: When no injection applies, mem_word carries wr_data in bits 31:0 and wr_check in bits 38:32 unchanged.
- R2: mem_we[k] is high exactly when wr_en is high and wr_ram equals k; at most one bit is ever high.
- R3: In a single-bit mode, a position code p from 0 to 31 inverts mem_word bit p only (bit 0 is the data LSB).
- R4: In a single-bit mode, a position code from 64 to 70 inverts check bit (code - 64), which is mem_word bit 32 + (code - 64).
- R5: Position codes 32 to 63 and 71 to 127 invert nothing in any mode.
- R6: In a two-bit mode, the selected bit and check bit 6 (mem_word bit 38) are both inverted; codes 64 and 70, and any code that selects no bit, invert nothing.
- R7: Injection applies only to a write (wr_en high) whose wr_ram equals the stored target index; other writes pass unchanged.
- R8: Mode encoding on ctl_mode: bit 0 continuous single, bit 1 one-shot single, bit 2 continuous two-bit, bit 3 one-shot two-bit. A one-shot mode is cleared to 0 in mode_q on the clock edge that ends the first qualifying write; a continuous mode stays until the next control write. A control write in the same cycle takes precedence over the clear.
- R9: A control write with two or more mode bits set stores the value, injects nothing while it is held, and sets illegal_seen from the next cycle on until reset.
- R10: After reset, mode_q is 0, illegal_seen is 0, the target index is 0 and words pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| ctl_we | input | 1 | Load the control register this cycle |
| ctl_mode | input | 4 | Mode enables to load (encoding in R8) |
| ctl_pos | input | 7 | Bit-position code to load |
| ctl_ram | input | 1 | Target RAM index to load |
| wr_en | input | 1 | A write to one RAM happens this cycle |
| wr_ram | input | 1 | Index of the RAM being written |
| wr_data | input | 32 | Write data from the bus side |
| wr_check | input | 7 | Check bits from the encoder |
| mem_word | output | 39 | Word to store, {check, data}, possibly corrupted |
| mem_we | output | 2 | Per-RAM write enable |
| mode_q | output | 4 | Current stored mode enables |
| illegal_seen | output | 1 | Sticky flag for a rejected mode combination |

## Verification
A wrong stored mode, position or target shows at mem_word in the same cycle as the next write to the targeted RAM, because the mask is applied combinationally to the write word. A one-shot that fails to clear, or clears on a write to the other RAM, shows in mode_q one edge after that write and in a second corrupted word on the following qualifying write. A lost or spurious sticky flag shows on illegal_seen one edge after the control write.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

  // Mode enables, bit 0 = continuous single-bit
  typedef struct packed {
    logic os_dbl;
    logic ct_dbl;
    logic os_sgl;
    logic ct_sgl;
  } inj_mode_t;

  function automatic logic mode_legal(input inj_mode_t m);
    return ($countones(m) <= 1);
  endfunction

  function automatic logic mode_oneshot(input inj_mode_t m);
    return m.os_sgl | m.os_dbl;
  endfunction

  function automatic logic mode_double(input inj_mode_t m);
    return m.ct_dbl | m.os_dbl;
  endfunction

endpackage

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int POS_W = 7,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  inj_mode_t        ctl_mode,
  input  logic [POS_W-1:0] ctl_pos,
  input  logic [SEL_W-1:0] ctl_ram,
  input  logic             fire,
  output inj_mode_t        mode_q,
  output logic [POS_W-1:0] pos_q,
  output logic [SEL_W-1:0] ram_q,
  output logic             illegal_q,
  output logic             active,
  output logic             dbl
);

  inj_mode_t        mode_d;
  logic [POS_W-1:0] pos_d;
  logic [SEL_W-1:0] ram_d;
  logic             illegal_d;
  logic             cfg_en;
  logic             os_clear;

  assign active = mode_legal(mode_q) && (mode_q != '0);
  assign dbl    = mode_double(mode_q);

  always_comb begin
    os_clear  = fire && mode_oneshot(mode_q);
    cfg_en    = ctl_we || os_clear;
    mode_d    = mode_q;
    pos_d     = pos_q;
    ram_d     = ram_q;
    if (ctl_we) begin
      mode_d = ctl_mode;
      pos_d  = ctl_pos;
      ram_d  = ctl_ram;
    end else if (os_clear) begin
      mode_d = '0;
    end
    illegal_d = illegal_q || (ctl_we && !mode_legal(ctl_mode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pos_q  <= '0;
      ram_q  <= '0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      pos_q  <= pos_d;
      ram_q  <= ram_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_d;
  end

  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_oneshot(mode_q) && !ctl_we) |=> (mode_q == '0)); // R8

  AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !mode_oneshot(mode_q)) |=> $stable(mode_q)); // R8

  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |=> illegal_q); // R9

  AST_ILLEGAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ($countones(ctl_mode) > 1)) |=> illegal_q); // R9

endmodule

// File: rtl/ecc_inj_mask.sv
module ecc_inj_mask #(
  parameter int DATA_W   = 32,
  parameter int CHK_W    = 7,
  parameter int POS_W    = 7,
  parameter int CHK_BASE = 64,
  parameter int PAR_BIT  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [POS_W-1:0]         pos,
  input  logic                     active,
  input  logic                     dbl,
  output logic [DATA_W+CHK_W-1:0]  mask
);

  localparam int WORD_W  = DATA_W + CHK_W;
  localparam int PAR_IDX = DATA_W + PAR_BIT;

  logic [WORD_W-1:0] sel_vec;
  logic [WORD_W-1:0] par_vec;
  logic              sel_hit;
  logic              dbl_ok;

  for (genvar i = 0; i < WORD_W; i++) begin : g_dec
    localparam int TGT = (i < DATA_W) ? i : (CHK_BASE + i - DATA_W);
    assign sel_vec[i] = (pos == POS_W'(TGT));
    assign par_vec[i] = (i == PAR_IDX);
  end

  assign sel_hit = |sel_vec;

  always_comb begin
    dbl_ok = sel_hit && (pos != POS_W'(CHK_BASE)) &&
             (pos != POS_W'(CHK_BASE + PAR_BIT));
    if (!active)      mask = '0;
    else if (!dbl)    mask = sel_vec;
    else if (dbl_ok)  mask = sel_vec | par_vec;
    else              mask = '0;
  end

  AST_MASK_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask) <= 2); // R6

  AST_GAP_NOFLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pos >= POS_W'(DATA_W) && pos < POS_W'(CHK_BASE)) |-> (mask == '0)); // R5

  AST_DBL_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dbl && mask != '0) |-> mask[PAR_IDX]); // R6

endmodule

// File: rtl/ecc_inj_route.sv
module ecc_inj_route #(
  parameter int NUM_RAM = 2,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_ram,
  input  logic [SEL_W-1:0]   ram_q,
  output logic [NUM_RAM-1:0] mem_we,
  output logic               hit
);

  for (genvar k = 0; k < NUM_RAM; k++) begin : g_we
    assign mem_we[k] = wr_en && (wr_ram == SEL_W'(k));
  end

  assign hit = wr_en && (wr_ram == ram_q);

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we)); // R2

  AST_WE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (mem_we == '0)); // R2

endmodule

// File: rtl/ecc_err_inject.sv
module ecc_err_inject
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CHK_W    = 7,
  parameter int POS_W    = 7,
  parameter int CHK_BASE = 64,
  parameter int PAR_BIT  = 6,
  parameter int NUM_RAM  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ctl_we,
  input  logic [3:0]                            ctl_mode,
  input  logic [POS_W-1:0]                      ctl_pos,
  input  logic [((NUM_RAM>1)?$clog2(NUM_RAM):1)-1:0] ctl_ram,
  input  logic                                  wr_en,
  input  logic [((NUM_RAM>1)?$clog2(NUM_RAM):1)-1:0] wr_ram,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic [CHK_W-1:0]                      wr_check,
  output logic [DATA_W+CHK_W-1:0]               mem_word,
  output logic [NUM_RAM-1:0]                    mem_we,
  output logic [3:0]                            mode_q,
  output logic                                  illegal_seen
);

  localparam int SEL_W  = (NUM_RAM > 1) ? $clog2(NUM_RAM) : 1;
  localparam int WORD_W = DATA_W + CHK_W;

  logic              rst_q1;
  logic              rst_s;
  inj_mode_t         mode_r;
  logic [POS_W-1:0]  pos_r;
  logic [SEL_W-1:0]  ram_r;
  logic              active;
  logic              dbl;
  logic              hit;
  logic              fire;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] raw_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_s  <= rst_q1;
    end
  end

  ecc_inj_ctrl #(.POS_W(POS_W), .SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .ctl_we    (ctl_we),
    .ctl_mode  (inj_mode_t'(ctl_mode)),
    .ctl_pos   (ctl_pos),
    .ctl_ram   (ctl_ram),
    .fire      (fire),
    .mode_q    (mode_r),
    .pos_q     (pos_r),
    .ram_q     (ram_r),
    .illegal_q (illegal_seen),
    .active    (active),
    .dbl       (dbl)
  );

  ecc_inj_mask #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .POS_W(POS_W),
    .CHK_BASE(CHK_BASE), .PAR_BIT(PAR_BIT)
  ) u_mask (
    .clk    (clk),
    .rst_n  (rst_s),
    .pos    (pos_r),
    .active (active),
    .dbl    (dbl),
    .mask   (mask)
  );

  ecc_inj_route #(.NUM_RAM(NUM_RAM), .SEL_W(SEL_W)) u_route (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr_en  (wr_en),
    .wr_ram (wr_ram),
    .ram_q  (ram_r),
    .mem_we (mem_we),
    .hit    (hit)
  );

  assign fire     = hit && active;
  assign raw_word = {wr_check, wr_data};
  assign mem_word = fire ? (raw_word ^ mask) : raw_word;
  assign mode_q   = mode_r;

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_s)
    !fire |-> (mem_word == {wr_check, wr_data})); // R1

  AST_OTHER_RAM: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && wr_ram != ram_r) |-> (mem_word == {wr_check, wr_data})); // R7

endmodule

// File: tb/ecc_err_inject_test.sv
module ecc_err_inject_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [3:0]  ctl_mode;
  logic [6:0]  ctl_pos;
  logic [0:0]  ctl_ram;
  logic        wr_en;
  logic [0:0]  wr_ram;
  logic [31:0] wr_data;
  logic [6:0]  wr_check;
  logic [38:0] mem_word;
  logic [1:0]  mem_we;
  logic [3:0]  mode_q;
  logic        illegal_seen;

  int total = 0;
  int bad   = 0;

  // bench model of the control state
  logic [3:0] m_mode;
  logic [6:0] m_pos;
  logic       m_ram;
  logic       m_ill;

  always #4 clk = ~clk;

  ecc_err_inject uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode),
    .ctl_pos(ctl_pos), .ctl_ram(ctl_ram), .wr_en(wr_en), .wr_ram(wr_ram),
    .wr_data(wr_data), .wr_check(wr_check), .mem_word(mem_word),
    .mem_we(mem_we), .mode_q(mode_q), .illegal_seen(illegal_seen)
  );

  function automatic logic legal(input logic [3:0] m);
    return (m == 4'h0) || (m == 4'h1) || (m == 4'h2) || (m == 4'h4) || (m == 4'h8);
  endfunction

  function automatic logic [38:0] exp_mask(input logic [3:0] m, input logic [6:0] p);
    logic [38:0] b;
    b = '0;
    if (!legal(m) || m == 4'h0) return '0;
    if (p < 7'd32) b[p[4:0]] = 1'b1;
    else if (p >= 7'd64 && p <= 7'd70) b[32 + int'(p) - 64] = 1'b1;
    if (m == 4'h4 || m == 4'h8) begin
      if (b == '0 || p == 7'd64 || p == 7'd70) return '0;
      b[38] = 1'b1;
    end
    return b;
  endfunction

  function automatic string word_tag(input logic en, input logic ram);
    if (!legal(m_mode)) return "R9";
    if (m_mode == 4'h0) return "R1";
    if (!en || ram != m_ram) return "R7";
    if (m_mode == 4'h4 || m_mode == 4'h8) return "R6";
    if (m_pos < 7'd32) return "R3";
    if (m_pos >= 7'd64 && m_pos <= 7'd70) return "R4";
    return "R5";
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] md, input logic [6:0] ps,
                      input logic rm, input logic en, input logic wram,
                      input logic [31:0] d, input logic [6:0] c);
    logic [38:0] ew;
    logic [1:0]  ewe;
    logic        fire;
    @(negedge clk);
    ctl_we = we; ctl_mode = md; ctl_pos = ps; ctl_ram = rm;
    wr_en = en; wr_ram = wram; wr_data = d; wr_check = c;
    #1;
    fire = en && (wram == m_ram) && legal(m_mode) && (m_mode != 4'h0);
    ew   = {c, d} ^ (fire ? exp_mask(m_mode, m_pos) : 39'd0);
    ewe  = en ? (wram ? 2'b10 : 2'b01) : 2'b00;
    check(mem_word == ew, word_tag(en, wram), 64'(mem_word), 64'(ew));
    check(mem_we == ewe, "R2", 64'(mem_we), 64'(ewe));
    check(mode_q == m_mode, "R8", 64'(mode_q), 64'(m_mode));
    check(illegal_seen == m_ill, "R9", 64'(illegal_seen), 64'(m_ill));
    @(posedge clk);
    if (we) begin
      m_mode = md; m_pos = ps; m_ram = rm;
      if (!legal(md)) m_ill = 1'b1;
    end else if (fire && (m_mode == 4'h2 || m_mode == 4'h8)) begin
      m_mode = 4'h0;
    end
  endtask

  task automatic cfg(input logic [3:0] md, input logic [6:0] ps, input logic rm);
    step(1'b1, md, ps, rm, 1'b0, 1'b0, $urandom, 7'($urandom));
  endtask

  task automatic wr(input logic rm);
    step(1'b0, 4'h0, 7'h0, 1'b0, 1'b1, rm, $urandom, 7'($urandom));
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    m_mode = 4'h0; m_pos = 7'h0; m_ram = 1'b0; m_ill = 1'b0;
    rst_n = 1'b0; ctl_we = 1'b0; ctl_mode = 4'h0; ctl_pos = 7'h0; ctl_ram = 1'b0;
    wr_en = 1'b0; wr_ram = 1'b0; wr_data = '0; wr_check = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: reset state, word passes on a write to RAM 0
    @(negedge clk); #1;
    check(mode_q == 4'h0, "R10", 64'(mode_q), 64'h0);
    check(illegal_seen == 1'b0, "R10", 64'(illegal_seen), 64'h0);
    wr(1'b0); wr(1'b1);

    // directed corners
    cfg(4'h1, 7'd0, 1'b0);  wr(1'b0);                 // R3 LSB
    cfg(4'h1, 7'd31, 1'b1); wr(1'b0); wr(1'b1);       // R3 MSB, R7 other RAM
    cfg(4'h1, 7'd64, 1'b0); wr(1'b0);                 // R4
    cfg(4'h1, 7'd70, 1'b0); wr(1'b0);                 // R4
    cfg(4'h1, 7'd32, 1'b0); wr(1'b0);                 // R5
    cfg(4'h1, 7'd71, 1'b0); wr(1'b0);                 // R5
    cfg(4'h4, 7'd5, 1'b0);  wr(1'b0); wr(1'b0);       // R6 continuous
    cfg(4'h4, 7'd64, 1'b0); wr(1'b0);                 // R6 no flip
    cfg(4'h4, 7'd70, 1'b0); wr(1'b0);                 // R6 no flip
    cfg(4'h4, 7'd66, 1'b0); wr(1'b0);                 // R6 check bit
    cfg(4'h2, 7'd9, 1'b1);  wr(1'b0); wr(1'b1); wr(1'b1); // R8 one-shot after other RAM
    cfg(4'h8, 7'd12, 1'b0); wr(1'b0); wr(1'b0);       // R8 one-shot two-bit
    cfg(4'h2, 7'd3, 1'b0);
    step(1'b1, 4'h2, 7'd4, 1'b0, 1'b1, 1'b0, 32'h0, 7'h0); // R8 write beats clear
    wr(1'b0);
    cfg(4'h3, 7'd1, 1'b0);  wr(1'b0); wr(1'b0);       // R9 illegal
    cfg(4'h1, 7'd2, 1'b0);  wr(1'b0);                 // R9 flag stays

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] md;
      logic [6:0] ps;
      int r;
      if ($urandom_range(0, 9) == 0) begin
        r = $urandom_range(0, 19);
        if (r == 0) md = 4'($urandom) | 4'h3;
        else begin
          case (r % 5)
            0: md = 4'h0;
            1: md = 4'h1;
            2: md = 4'h2;
            3: md = 4'h4;
            default: md = 4'h8;
          endcase
        end
        r = $urandom_range(0, 9);
        if (r < 4)      ps = 7'($urandom_range(0, 31));
        else if (r < 7) ps = 7'($urandom_range(64, 70));
        else            ps = 7'($urandom);
        step(1'b1, md, ps, 1'($urandom), 1'($urandom), 1'($urandom),
             $urandom, 7'($urandom));
      end else begin
        step(1'b0, 4'($urandom), 7'($urandom), 1'($urandom),
             ($urandom_range(0, 9) < 7), 1'($urandom), $urandom, 7'($urandom));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule